// File: doc/BRIEF.md
# Serial Slave Shifter with Pause Input

This block is the bit-level front end of a mode-0 serial peripheral slave. It watches a serial clock, an active-low select, a serial data input and an active-low pause input. It assembles incoming bits into bytes, most significant bit first, and shifts an outgoing byte onto a serial data output. That output has a separate enable so the pad can be tri-stated. Everything runs on a faster system clock, and a short flop chain synchronises each serial input before use.

The pause input lets the host stop a transfer in the middle of a byte and continue later without sending anything again. While paused, the output enable drops and the bit position, receive shift state and transmit shift state are frozen. Serial clock and data activity has no effect during the pause. Entering or leaving the pause is only recognised while the serial clock is low. A pause level that changes while the clock is high is acted on at the next low phase. When the pause feature is not used, the pause input is held high.

Received bytes appear on a parallel output with a one-cycle strobe. The byte to send is taken from a parallel input at select time and at every byte boundary, and a one-cycle acknowledge marks each capture. Decoding the command stream and any storage behind it belong to the neighbouring logic.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, `so_oe_o` is 0, `rx_valid_o` is 0 and `rx_data_o` is 0.
- R2: `si_i` is sampled on each rising edge of `sck_i`, first bit is the most significant. After the eighth sample, `rx_data_o` holds the byte and `rx_valid_o` is high for exactly one system clock.
- R3: After `csn_i` falls, `so_o` shows bit 7 of the byte captured from `tx_data_i`. Each falling edge of `sck_i` moves `so_o` to the next lower bit. `so_oe_o` is 1 while selected and not paused.
- R4: `tx_data_i` is captured when `csn_i` falls and at the eighth rising edge of each byte, so the next byte's bit 7 appears after the following falling edge. `tx_taken_o` pulses once for each capture.
- R5: `holdn_i` going low while `sck_i` is low enters the pause, and `so_oe_o` goes to 0.
- R6: While paused, edges on `sck_i` and changes on `si_i` change neither the received byte nor the bit position, and `rx_valid_o` does not pulse.
- R7: `holdn_i` going high while `sck_i` is low leaves the pause. `so_oe_o` returns to 1, `so_o` shows the same bit it showed before the pause, and the byte completes from the bit where it stopped.
- R8: A change of `holdn_i` while `sck_i` is high has no effect until `sck_i` is low. A falling `sck_i` edge that ends such a high phase is itself ignored.
- R9: `csn_i` high resets the bit position to the start of a byte, clears the pause and drives `so_oe_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, idles low (mode 0) |
| csn_i | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| holdn_i | input | 1 | Active-low pause; hold high when unused |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for the serial data out pad |
| rx_data_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe, new byte on `rx_data_o` |
| tx_data_i | input | 8 | Next byte to transmit |
| tx_taken_o | output | 1 | One-cycle strobe, `tx_data_i` was captured |

## Verification
A bit counter that slips, or that runs during a pause, shows up as a received byte that is rotated or mixed with pause-time junk. It also makes `rx_valid_o` fire at the wrong serial edge, within one byte time of the fault. A wrong pause state appears on `so_oe_o` about three system clocks after the serial pins settle. A transmit register that shifts when it should not shows up as a wrong `so_o` bit at the very next rising serial edge. The bench therefore compares every output bit before each rising edge and every received byte against a queue.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    // Serial pins after synchronisation, packed for one flop chain.
    typedef struct packed {
        logic sck;
        logic csn;
        logic si;
        logic holdn;
    } pins_t;

    localparam int unsigned PIN_COUNT = $bits(pins_t);

    // Idle pin levels: clock low, deselected, data low, not paused.
    localparam pins_t PIN_IDLE = '{sck: 1'b0, csn: 1'b1, si: 1'b0, holdn: 1'b1};

    // Per-cycle events from the controller to the shifter.
    typedef struct packed {
        logic active;  // selected
        logic start;   // select just asserted
        logic rise;    // usable rising serial edge
        logic fall;    // usable falling serial edge
        logic paused;  // pause state in force
    } evt_t;

    function automatic logic is_last_bit(input int unsigned cnt, input int unsigned width);
        return cnt == width - 1;
    endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("sync chain needs two stages");
    end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    input  logic csn_s,
    input  logic holdn_s,
    output evt_t ev
);
    logic sck_q;
    logic csn_q;
    logic paused_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            csn_q    <= 1'b1;
            paused_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
            if (csn_s) begin
                paused_q <= 1'b0;
            end else if (!sck_s) begin
                paused_q <= !holdn_s;
            end
        end
    end

    always_comb begin
        ev.active = !csn_s;
        ev.start  = csn_q && !csn_s;
        ev.paused = paused_q;
        ev.rise   = ev.active && !ev.start && !paused_q && sck_s && !sck_q;
        ev.fall   = ev.active && !ev.start && !paused_q && !sck_s && sck_q;
    end

    // R8: pause state may only change during a low clock phase or on deselect
    assert_pause_at_sck_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(paused_q) |-> (!$past(sck_s) || $past(csn_s)));

    // R9: deselect clears the pause
    assert_deselect_unpause_R9: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !paused_q);
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift
    import spi_hold_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         ev,
    input  logic         si_s,
    input  logic [W-1:0] tx_data_i,
    output logic         so_o,
    output logic         so_oe_o,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o,
    output logic         tx_taken_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  tx_sh;
    logic          so_q;
    logic          oe_q;
    logic [W-1:0]  rx_byte;

    assign rx_byte = {rx_sh[W-2:0], si_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            so_q       <= 1'b0;
            oe_q       <= 1'b0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
            tx_taken_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            tx_taken_o <= 1'b0;
            oe_q       <= ev.active && !ev.paused;
            if (!ev.active) begin
                bit_cnt <= '0;
            end else if (ev.start) begin
                bit_cnt    <= '0;
                so_q       <= tx_data_i[W-1];
                tx_sh      <= {tx_data_i[W-2:0], 1'b0};
                tx_taken_o <= 1'b1;
            end else if (ev.rise) begin
                rx_sh <= rx_byte;
                if (is_last_bit(int'(bit_cnt), W)) begin
                    bit_cnt    <= '0;
                    rx_data_o  <= rx_byte;
                    rx_valid_o <= 1'b1;
                    tx_sh      <= tx_data_i;
                    tx_taken_o <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (ev.fall) begin
                so_q  <= tx_sh[W-1];
                tx_sh <= tx_sh << 1;
            end
        end
    end

    assign so_o    = so_q;
    assign so_oe_o = oe_q;

    // R6: bit position frozen while paused
    assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.active && !ev.start && ev.paused) |=> $stable(bit_cnt));

    // R2: byte strobe lasts one cycle and leaves the counter at byte start
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> (bit_cnt == '0) ##1 !rx_valid_o);

    // R4: every byte strobe comes with a transmit capture
    assert_tx_capture_R4: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> tx_taken_o);

    // R5: pause state removes the output drive
    assert_paused_oe_R5: assert property (@(posedge clk) disable iff (rst)
        ev.paused |=> !so_oe_o);

    // R9: deselect returns counter to zero and removes the drive
    assert_deselect_oe_R9: assert property (@(posedge clk) disable iff (rst)
        !ev.active |=> (bit_cnt == '0 && !so_oe_o));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
    import spi_hold_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck_i,
    input  logic         csn_i,
    input  logic         si_i,
    input  logic         holdn_i,
    output logic         so_o,
    output logic         so_oe_o,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o,
    input  logic [W-1:0] tx_data_i,
    output logic         tx_taken_o
);
    pins_t pin_raw;
    pins_t pin_s;
    evt_t  ev;

    assign pin_raw = '{sck: sck_i, csn: csn_i, si: si_i, holdn: holdn_i};

    spi_hold_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_raw),
        .q  (pin_s)
    );

    spi_hold_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (pin_s.sck),
        .csn_s  (pin_s.csn),
        .holdn_s(pin_s.holdn),
        .ev     (ev)
    );

    spi_hold_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .si_s      (pin_s.si),
        .tx_data_i (tx_data_i),
        .so_o      (so_o),
        .so_oe_o   (so_oe_o),
        .rx_data_o (rx_data_o),
        .rx_valid_o(rx_valid_o),
        .tx_taken_o(tx_taken_o)
    );
endmodule

// File: tb/spi_hold_slave_bench.sv
`timescale 1ns/1ps
module spi_hold_slave_bench;
    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       csn = 1'b1;
    logic       si = 1'b0;
    logic       holdn = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       so, so_oe, rx_valid, tx_taken;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int taken_cnt = 0;
    int exp_taken = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    spi_hold_slave u_spi_hold_slave (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .si_i(si),
        .holdn_i(holdn), .so_o(so), .so_oe_o(so_oe), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .tx_data_i(tx_data), .tx_taken_o(tx_taken)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each byte strobe.
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check_eq("R6 unexpected byte strobe", int'(rx_data), -1);
                end else begin
                    check_eq("R2 received byte", int'(rx_data), int'(exp_q.pop_front()));
                end
            end
            if (tx_taken) taken_cnt++;
        end
    end

    task automatic select_dev();
        csn = 1'b0;
        exp_taken++;
        wait_clk(HP);
    endtask

    task automatic deselect_dev();
        csn = 1'b1;
        wait_clk(HP);
        check_eq("R9 output enable after deselect", int'(so_oe), 0);
    endtask

    // Driver: bits hi..lo of one byte, checking SO before each rising edge.
    task automatic send_bits(input logic [7:0] mosi, input logic [7:0] miso,
                             input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            si = mosi[i];
            wait_clk(HP);
            check_eq("R3 serial out bit", int'(so), int'(miso[i]));
            check_eq("R3 output enable", int'(so_oe), 1);
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] mosi, input logic [7:0] miso,
                             input logic [7:0] next_tx);
        exp_q.push_back(mosi);
        exp_taken++;
        tx_data = next_tx;
        send_bits(mosi, miso, 7, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1: reset state
        check_eq("R1 output enable", int'(so_oe), 0);
        check_eq("R1 byte strobe", int'(rx_valid), 0);
        check_eq("R1 received byte", int'(rx_data), 0);

        // R2/R3/R4: two back-to-back bytes in one selection
        tx_data = 8'h96;
        select_dev();
        send_byte(8'hA5, 8'h96, 8'h5A);
        send_byte(8'h3C, 8'h5A, 8'h00);
        wait_clk(HP);
        deselect_dev();

        // R5..R8: pause in mid-byte
        tx_data = 8'hC3;
        select_dev();
        exp_q.push_back(8'h6B);
        exp_taken++;
        send_bits(8'h6B, 8'hC3, 7, 4);
        holdn = 1'b0;
        wait_clk(HP);
        check_eq("R5 output enable while paused", int'(so_oe), 0);
        for (int k = 0; k < 3; k++) begin
            si = ~si;
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
            wait_clk(HP);
        end
        check_eq("R6 output enable still off", int'(so_oe), 0);
        sck = 1'b1;
        wait_clk(HP);
        holdn = 1'b1;
        wait_clk(HP);
        check_eq("R8 release with clock high deferred", int'(so_oe), 0);
        sck = 1'b0;
        wait_clk(HP);
        check_eq("R7 output enable after resume", int'(so_oe), 1);
        check_eq("R7 same output bit after resume", int'(so), 0);
        send_bits(8'h6B, 8'hC3, 3, 0);
        wait_clk(HP);
        deselect_dev();

        // R9: deselect mid-byte restarts the bit position
        tx_data = 8'h81;
        select_dev();
        send_bits(8'h55, 8'h81, 7, 5);
        deselect_dev();
        tx_data = 8'hE7;
        select_dev();
        send_byte(8'h3A, 8'hE7, 8'h00);
        wait_clk(HP);

        // R9: deselect during a pause clears it
        tx_data = 8'h24;
        deselect_dev();
        select_dev();
        holdn = 1'b0;
        wait_clk(HP);
        check_eq("R5 pause at byte start", int'(so_oe), 0);
        csn = 1'b1;
        wait_clk(HP);
        holdn = 1'b1;
        select_dev();
        check_eq("R9 pause cleared on reselect", int'(so_oe), 1);
        send_byte(8'hF0, 8'h24, 8'h00);
        wait_clk(HP);
        deselect_dev();

        wait_clk(4);
        check_eq("R4 transmit capture count", taken_cnt, exp_taken);
        check_eq("R2 all bytes received", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule